// File: doc/BRIEF.md
# Manchester Packet Serializer

This block turns a packet of 16-bit words, held in a transmit FIFO next to it, into a phase-encoded serial bit stream. Every line bit lasts two system clocks. Each half of the bit occupies one clock, and the two halves always carry opposite levels. A packet begins with one sync bit, carries the message words most significant bit first, and ends with a 16-bit CRC that is generated while the data bits go out.

Transmission is gated. Software first lets a countdown run out. The line must then be quiet, meaning no carrier is sensed. Finally, enough of the message must be buffered: either the FIFO is completely full, or a message shorter than the FIFO depth is loaded in full. If the transceiver reports a collision, the block stops driving the line. It then latches a sticky flag and holds a service request until the next reset, and it refuses to start a new packet during that time.

Top module: `manch_tx`

## Requirements
- R1: While no packet is in progress (`tx_active` low), `tx_out` is low. After reset, `tx_active`, `tx_out`, `tx_done`, `coll_flag` and `svc_req` are all low.
- R2: Every line bit spans two clocks. A 1 is sent as high in the first clock and low in the second; a 0 is sent as low then high.
- R3: The first line bit of every packet is a single 1 (the sync bit). The first data bit follows it.
- R4: Exactly `msg_len` words are sent, in FIFO order, each most significant bit first, with no gap between words.
- R5: After the last data word come 16 CRC bits, most significant first. The CRC uses polynomial x^16+x^15+x^2+1 (0x8005), starts from zero and is fed the data bits MSB first. Running the same CRC over the received data bits followed by the CRC bits gives zero.
- R6: A packet may start only when `countdown_done` is high and `carrier_sense` is low. While carrier is present nothing starts, even if every other condition holds.
- R7: In addition, one of two conditions must hold. Either `fifo_count` equals the FIFO depth (16), or `msg_len` is below 16 and `fifo_count` is at least `msg_len`. A message that is only partly loaded does not start.
- R8: `tx_done` is high for exactly one clock, the clock right after the last CRC half-bit.
- R9: A high `collision` sets `coll_flag` and `svc_req` on the next clock. They stay set until reset. The packet is abandoned, so the line is idle from that clock on, and no new packet starts while the flag is set.
- R10: `fifo_rd_en` pulses once in the clock a packet starts and once at each word boundary where another word is due. This gives exactly `msg_len` pops per packet.
- R11: A low `rst_n`, sampled at a clock edge, clears the collision flag, the CRC register and the serializer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one half-bit per period |
| rst_n | input | 1 | Synchronous reset, active low |
| countdown_done | input | 1 | Software countdown has expired |
| carrier_sense | input | 1 | Another transmission is on the medium |
| collision | input | 1 | Interference report from the transceiver |
| msg_len | input | 8 | Number of words in the current message |
| fifo_count | input | 5 | Words currently held in the transmit FIFO |
| fifo_data | input | 16 | Head word of the FIFO (show-ahead) |
| fifo_rd_en | output | 1 | Pops the head word of the FIFO |
| tx_out | output | 1 | Phase-encoded serial line |
| tx_active | output | 1 | A packet is being sent |
| tx_done | output | 1 | One-clock pulse when a packet completes |
| coll_flag | output | 1 | Sticky collision flag |
| svc_req | output | 1 | Service request raised by a collision |

## Verification
The assertions check the rules that are local in time on every cycle. These are: the line is low when idle; the second half of each bit is the opposite of the first; no FIFO pop starts a packet while carrier is present or the countdown is still running; `tx_done` lasts a single clock; and a collision sets the flag and drops activity on the next clock. Other properties span a whole packet and can only be shown by the bench scenarios. These are the exact bit sequence (sync, word order, MSB first), the CRC value and its zero remainder at a receiver, the full-FIFO and short-message start rules, the refill of a message longer than the FIFO, and the blocking of new starts after a collision until reset.

// File: rtl/manch_tx_pkg.sv
// Package: shared types for the Manchester packet serializer.
// Assumes nothing beyond IEEE 1800-2017.
package manch_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2,
        ST_CRC  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/manch_tx_gate.sv
// Start gate: decides whether a new packet may begin this clock.
// Assumes fifo_count never exceeds FIFO_DEPTH and LEN_W >= CNT_W.
module manch_tx_gate #(
    parameter int FIFO_DEPTH = 16,
    parameter int LEN_W      = 8,
    parameter int CNT_W      = 5
) (
    input  logic             idle,
    input  logic             countdown_done,
    input  logic             carrier_sense,
    input  logic             coll_flag,
    input  logic [LEN_W-1:0] msg_len,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             start_ok
);
    logic buf_full;
    logic short_loaded;

    // Purpose: evaluate the buffering rule and the medium/countdown rule.
    always_comb begin
        buf_full     = (fifo_count == CNT_W'(FIFO_DEPTH));
        short_loaded = (msg_len != '0) && (msg_len < LEN_W'(FIFO_DEPTH))
                       && (LEN_W'(fifo_count) >= msg_len);
        start_ok     = idle && countdown_done && !carrier_sense && !coll_flag
                       && (buf_full || short_loaded);
    end
endmodule

// File: rtl/manch_tx_crc.sv
// One serial CRC step: next remainder after one input bit, MSB first.
// Assumes the caller holds the remainder register and the preset value.
module manch_tx_crc #(
    parameter int          CRC_W    = 16,
    parameter logic [15:0] CRC_POLY = 16'h8005
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_out
);
    logic fb;

    // Purpose: shift the remainder and fold the polynomial on feedback.
    always_comb begin
        fb      = crc_in[CRC_W-1] ^ bit_in;
        crc_out = {crc_in[CRC_W-2:0], 1'b0} ^ (fb ? CRC_W'(CRC_POLY) : '0);
    end
endmodule

// File: rtl/manch_tx_coll.sv
// Collision latch: sticky flag plus service request, cleared only by reset.
// Assumes collision is already synchronous to clk.
module manch_tx_coll (
    input  logic clk,
    input  logic rst_n,
    input  logic collision,
    output logic coll_flag,
    output logic svc_req
);
    logic flag_q;

    // Purpose: latch any collision report until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else if (collision) flag_q <= 1'b1;
    end

    assign coll_flag = flag_q;
    assign svc_req   = flag_q;
endmodule

// File: rtl/manch_tx.sv
// Manchester packet serializer top: sync bit, FIFO words MSB first, then CRC.
// Assumes a show-ahead FIFO whose head word stays valid until popped, that a
// long message is refilled before each word is due, and WORD_W a power of two.
module manch_tx
    import manch_tx_pkg::*;
#(
    parameter int          WORD_W     = 16,
    parameter int          FIFO_DEPTH = 16,
    parameter int          LEN_W      = 8,
    parameter logic [15:0] CRC_POLY   = 16'h8005,
    localparam int         CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              countdown_done,
    input  logic              carrier_sense,
    input  logic              collision,
    input  logic [LEN_W-1:0]  msg_len,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_rd_en,
    output logic              tx_out,
    output logic              tx_active,
    output logic              tx_done,
    output logic              coll_flag,
    output logic              svc_req
);
    localparam int BIT_CW = $clog2(WORD_W);

    tx_state_e         st_q;
    logic              ph_q;
    logic [BIT_CW-1:0] bit_q;
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] crc_q;
    logic [WORD_W-1:0] crc_nx;
    logic [LEN_W-1:0]  left_q;
    logic              done_q;
    logic              start_ok;
    logic              cur_bit;
    logic              last_bit;
    logic              more_words;
    logic              word_end;

    manch_tx_gate #(.FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) i_gate (
        .idle           (st_q == ST_IDLE),
        .countdown_done (countdown_done),
        .carrier_sense  (carrier_sense),
        .coll_flag      (coll_flag),
        .msg_len        (msg_len),
        .fifo_count     (fifo_count),
        .start_ok       (start_ok)
    );

    manch_tx_crc #(.CRC_W(WORD_W), .CRC_POLY(CRC_POLY)) i_crc (
        .crc_in  (crc_q),
        .bit_in  (sh_q[WORD_W-1]),
        .crc_out (crc_nx)
    );

    manch_tx_coll i_coll (
        .clk       (clk),
        .rst_n     (rst_n),
        .collision (collision),
        .coll_flag (coll_flag),
        .svc_req   (svc_req)
    );

    // Purpose: decode the bit being sent and the word-boundary pop.
    always_comb begin
        cur_bit    = (st_q == ST_SYNC) ? 1'b1 : sh_q[WORD_W-1];
        last_bit   = (bit_q == BIT_CW'(WORD_W - 1));
        more_words = (left_q != '0);
        word_end   = (st_q == ST_DATA) && ph_q && last_bit;
        fifo_rd_en = start_ok || (word_end && more_words && !collision);
    end

    // Purpose: sequence sync, data and CRC half-bits; abort on collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ph_q   <= 1'b0;
            bit_q  <= '0;
            sh_q   <= '0;
            crc_q  <= '0;
            left_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (collision) begin
                st_q <= ST_IDLE;
                ph_q <= 1'b0;
            end else begin
                case (st_q)
                    ST_IDLE: begin
                        if (start_ok) begin
                            st_q   <= ST_SYNC;
                            ph_q   <= 1'b0;
                            bit_q  <= '0;
                            sh_q   <= fifo_data;
                            crc_q  <= '0;
                            left_q <= msg_len - LEN_W'(1);
                        end
                    end
                    ST_SYNC: begin
                        ph_q <= ~ph_q;
                        if (ph_q) st_q <= ST_DATA;
                    end
                    ST_DATA: begin
                        ph_q <= ~ph_q;
                        if (ph_q) begin
                            crc_q <= crc_nx;
                            bit_q <= bit_q + BIT_CW'(1);
                            if (last_bit) begin
                                if (more_words) begin
                                    sh_q   <= fifo_data;
                                    left_q <= left_q - LEN_W'(1);
                                end else begin
                                    st_q <= ST_CRC;
                                    sh_q <= crc_nx;
                                end
                            end else begin
                                sh_q <= sh_q << 1;
                            end
                        end
                    end
                    ST_CRC: begin
                        ph_q <= ~ph_q;
                        if (ph_q) begin
                            bit_q <= bit_q + BIT_CW'(1);
                            sh_q  <= sh_q << 1;
                            if (last_bit) begin
                                st_q   <= ST_IDLE;
                                done_q <= 1'b1;
                            end
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign tx_active = (st_q != ST_IDLE);
    assign tx_out    = tx_active && (cur_bit ^ ph_q);
    assign tx_done   = done_q;
endmodule

// File: rtl/manch_tx_chk.sv
// Checker for manch_tx: cycle-local rules on the line and start/collision logic.
// Assumes it is bound into manch_tx and sees its half-bit phase register.
module manch_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic countdown_done,
    input logic carrier_sense,
    input logic collision,
    input logic fifo_rd_en,
    input logic tx_out,
    input logic tx_active,
    input logic tx_done,
    input logic coll_flag,
    input logic svc_req,
    input logic ph_q
);
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !tx_out);

    assert_second_half_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && ph_q) |-> (tx_out != $past(tx_out)));

    assert_start_needs_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && fifo_rd_en) |-> (countdown_done && !carrier_sense && !coll_flag));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    assert_done_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !tx_active);

    assert_collision_latches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> (coll_flag && svc_req && !tx_active));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        coll_flag |=> coll_flag);
endmodule

bind manch_tx manch_tx_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .countdown_done (countdown_done),
    .carrier_sense  (carrier_sense),
    .collision      (collision),
    .fifo_rd_en     (fifo_rd_en),
    .tx_out         (tx_out),
    .tx_active      (tx_active),
    .tx_done        (tx_done),
    .coll_flag      (coll_flag),
    .svc_req        (svc_req),
    .ph_q           (ph_q)
);

// File: tb/test_manch_tx.sv
// Scoreboard bench: driver tasks queue expected half-bits, a monitor compares.
module test_manch_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        countdown_done = 1'b0;
    logic        carrier_sense = 1'b0;
    logic        collision = 1'b0;
    logic [7:0]  msg_len = '0;
    logic [4:0]  fifo_count;
    logic [15:0] fifo_data;
    logic        fifo_rd_en, tx_out, tx_active, tx_done, coll_flag, svc_req;

    int checks = 0;
    int failures = 0;

    // bench FIFO model (show-ahead)
    logic [15:0] mem [0:63];
    logic [5:0]  wp = '0;
    logic [5:0]  rp;
    assign fifo_data  = mem[rp];
    assign fifo_count = 5'(wp - rp);

    always @(posedge clk) begin
        if (!rst_n) rp <= '0;
        else if (fifo_rd_en) rp <= rp + 6'd1;
    end

    always #10 clk = ~clk;   // 50 MHz

    manch_tx i_manch_tx (
        .clk(clk), .rst_n(rst_n), .countdown_done(countdown_done),
        .carrier_sense(carrier_sense), .collision(collision), .msg_len(msg_len),
        .fifo_count(fifo_count), .fifo_data(fifo_data), .fifo_rd_en(fifo_rd_en),
        .tx_out(tx_out), .tx_active(tx_active), .tx_done(tx_done),
        .coll_flag(coll_flag), .svc_req(svc_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_add(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h8005;
        return c;
    endfunction

    // scoreboard state
    logic        exp_q [$];
    logic        rx_q [$];
    bit          sb_on = 1'b0;
    int          half_idx = 0;
    int          cur_words = 0;
    bit          saw_active = 1'b0;
    logic [15:0] words [0:31];

    // Monitor: pop one expected half-bit per active clock, sampled at negedge.
    always @(negedge clk) begin
        if (tx_active) saw_active = 1'b1;
        if (sb_on && tx_active) begin
            string req;
            logic  e;
            if (half_idx < 2) req = "R3 sync bit";
            else if (half_idx < 2 + 32 * cur_words) req = "R4/R2 data half-bit";
            else req = "R5 crc half-bit";
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 extra half-bit after packet end", 32'(tx_out), 0);
            end else begin
                e = exp_q.pop_front();
                chk(tx_out == e, req, 32'(tx_out), 32'(e));
            end
            if (half_idx >= 2 && half_idx[0] == 1'b0) rx_q.push_back(tx_out);
            half_idx++;
        end
    end

    task automatic push_bit(input logic b);
        exp_q.push_back(b);
        exp_q.push_back(~b);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        countdown_done = 1'b0;
        carrier_sense = 1'b0;
        collision = 1'b0;
        msg_len = '0;
        wp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_word(input logic [15:0] w);
        mem[wp] = w;
        wp = wp + 6'd1;
    endtask

    // Driver: queue the expected stream, feed the FIFO, wait for completion.
    task automatic send_pkt(input int n);
        logic [15:0] c;
        logic [15:0] rc;
        int loaded;
        int guard;
        c = '0;
        exp_q.delete();
        rx_q.delete();
        push_bit(1'b1);
        for (int w = 0; w < n; w++)
            for (int b = 15; b >= 0; b--) begin
                push_bit(words[w][b]);
                c = crc_add(c, words[w][b]);
            end
        for (int b = 15; b >= 0; b--) push_bit(c[b]);
        half_idx = 0;
        cur_words = n;
        loaded = 0;
        while (loaded < n && loaded < 16) begin
            load_word(words[loaded]);
            loaded++;
        end
        msg_len = 8'(n);
        sb_on = 1'b1;
        countdown_done = 1'b1;
        guard = 0;
        while (!tx_done && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (tx_active) countdown_done = 1'b0;
            if (loaded < n && fifo_count < 5'd16) begin
                load_word(words[loaded]);
                loaded++;
            end
        end
        chk(tx_done == 1'b1, "R8 done pulse seen", 32'(tx_done), 1);
        chk(exp_q.size() == 0, "R8 done right after last crc half-bit",
            32'(exp_q.size()), 0);
        chk(fifo_count == 5'd0, "R10 all words popped", 32'(fifo_count), 0);
        rc = '0;
        foreach (rx_q[i]) rc = crc_add(rc, rx_q[i]);
        chk(rx_q.size() == 16 * n + 16 && rc == 16'h0, "R5 receiver remainder zero",
            32'(rc), 0);
        sb_on = 1'b0;
        @(negedge clk);
        chk(tx_done == 1'b0 && tx_out == 1'b0, "R8/R1 done one clock, line idle",
            {30'd0, tx_done, tx_out}, 0);
    endtask

    task automatic expect_no_start(input string req);
        saw_active = 1'b0;
        repeat (20) @(negedge clk);
        chk(!saw_active && tx_out == 1'b0, req, 32'(saw_active), 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        do_reset();
        // R1/R11: reset state
        chk({tx_active, tx_out, tx_done, coll_flag, svc_req} == 5'b0,
            "R1 R11 reset outputs", {27'd0, tx_active, tx_out, tx_done, coll_flag, svc_req}, 0);

        // R6: carrier blocks a fully loaded short message
        load_word(16'h1234); load_word(16'h5678); load_word(16'h9abc);
        msg_len = 8'd3; countdown_done = 1'b1; carrier_sense = 1'b1;
        expect_no_start("R6 carrier blocks start");
        chk(fifo_count == 5'd3, "R6 no pop under carrier", 32'(fifo_count), 3);
        // R6: countdown not expired
        carrier_sense = 1'b0; countdown_done = 1'b0;
        expect_no_start("R6 countdown blocks start");
        // R7: partly loaded short message
        msg_len = 8'd4; countdown_done = 1'b1;
        expect_no_start("R7 partial short message blocks start");
        do_reset();

        // R2 R3 R4 R5: short message of three words
        words[0] = 16'h1234; words[1] = 16'h5678; words[2] = 16'h9abc;
        send_pkt(3);
        do_reset();

        // edge patterns: single word of all zeros, then all ones
        words[0] = 16'h0000;
        send_pkt(1);
        words[0] = 16'hffff;
        send_pkt(1);
        do_reset();

        // R7/R10: 20-word message, starts on full FIFO, refilled in flight
        for (int i = 0; i < 20; i++) words[i] = 16'(i * 16'h1357 + 16'h00a5);
        send_pkt(20);
        do_reset();

        // R9: collision mid-packet
        load_word(16'hbeef); load_word(16'hcafe); load_word(16'h0f0f); load_word(16'hf0f0);
        msg_len = 8'd4; countdown_done = 1'b1;
        repeat (40) @(negedge clk);
        chk(tx_active == 1'b1, "R9 packet in flight before collision", 32'(tx_active), 1);
        collision = 1'b1;
        @(negedge clk);
        collision = 1'b0;
        chk(coll_flag && svc_req && !tx_active && !tx_out, "R9 collision latched, line idle",
            {28'd0, coll_flag, svc_req, tx_active, tx_out}, 32'hc);
        msg_len = 8'(fifo_count);
        expect_no_start("R9 no start while flag set");
        chk(coll_flag == 1'b1, "R9 flag sticky", 32'(coll_flag), 1);
        do_reset();
        chk(coll_flag == 1'b0 && svc_req == 1'b0, "R11 reset clears collision flag",
            {30'd0, coll_flag, svc_req}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule